// File: doc/BRIEF.md
# Paged address translation unit

This block turns a logical address from one process into a physical address under single-level paging. The low bits of the address are the offset within a page. The remaining upper bits are the page number. The page number is looked up in a small fully associative translation buffer. In the same cycle, a read of the page-table entry is started toward memory. If the buffer hits, that read is cancelled, so a hit costs one cycle and no memory traffic.

On a miss, the unit waits for the entry to come back from memory. It checks the entry's valid bit, loads the buffer with the frame number and answers. Every request is first compared against the page-table length. A request that falls outside the table gets a bounds fault. An entry whose valid bit is clear gets a protection fault. Neither kind of fault is ever placed in the buffer.

A flush input empties the buffer when the running process changes. Only one translation is in flight at a time.

Top module: `page_xlate`

## Requirements
- R1: The physical address is the frame number in the upper bits joined with the logical offset (low PAGE_BITS bits, default 12) unchanged, including offsets 0 and all-ones.
- R2: In the cycle a request is accepted, the unit raises a one-cycle page-table read at address base + page_number * 8.
- R3: On a buffer hit inside the table bounds, the response arrives one cycle after acceptance with fault code 0, and the read cancel is high in that response cycle.
- R4: On a miss, the response comes one cycle after the memory data strobe. A page-table entry carries its valid flag in bit 63 and its frame number in bits [PA_W-PAGE_BITS-1:0].
- R5: A page number not less than the length register gives fault code 1 one cycle after acceptance, with the read cancelled. No buffer entry is made, so the same page later misses once the length is raised.
- R6: An entry with bit 63 clear gives fault code 2 and is not loaded, so a repeat request for that page misses again.
- R7: A valid miss loads the page into the buffer, so the next request to the same page hits.
- R8: A refill goes to the lowest-numbered empty entry. When the buffer is full, it goes to a round-robin victim that starts at entry 0 and advances only on such evictions.
- R9: A flush pulse empties the whole buffer in one cycle and holds the request ready low while it is asserted. Every page misses afterwards.
- R10: The request ready is high when idle and low from acceptance through the response cycle. The response valid is a one-cycle pulse.
- R11: Fault codes are 0 none, 1 bounds, 2 invalid; code 3 never appears, and a faulted response carries an all-zero address.
- R12: A flush arriving while a miss waits for memory discards that refill. The response is still delivered, and the page misses afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Unit can accept a request |
| req_laddr_i | input | LA_W | Logical address |
| rsp_valid_o | output | 1 | Response valid pulse |
| rsp_paddr_o | output | PA_W | Physical address (zero on fault) |
| rsp_fault_o | output | 2 | Fault code: 0 none, 1 bounds, 2 invalid |
| mem_rd_valid_o | output | 1 | Page-table read request |
| mem_rd_addr_o | output | MEM_AW | Byte address of the page-table entry |
| mem_rd_cancel_o | output | 1 | Withdraw the read issued in the previous cycle |
| mem_rd_data_valid_i | input | 1 | Page-table entry returned |
| mem_rd_data_i | input | MEM_DW | Page-table entry |
| ptbr_i | input | MEM_AW | Page-table base byte address |
| ptlr_i | input | LA_W-PAGE_BITS+1 | Page-table length in entries |
| flush_i | input | 1 | Invalidate every buffer entry |

## Verification
The assertions take the base and length registers to be stable while a translation is outstanding. The bounds property compares against the current length, and the offset property compares against the address captured at acceptance. They also take memory to return each uncancelled read exactly once and never to answer a cancelled one. The requester must take every response pulse. The bench changes the length and base only while the unit is idle. Its memory model tracks a single pending read, drops that read on cancel and answers after a fixed three-cycle latency. Response backpressure is never needed.

// File: rtl/page_xlate_pkg.sv
package page_xlate_pkg;
  typedef enum logic [1:0] {
    FLT_NONE    = 2'd0,
    FLT_BOUNDS  = 2'd1,
    FLT_INVALID = 2'd2
  } fault_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_WAIT = 2'd1,
    S_DONE = 2'd2
  } xlate_state_e;

  localparam int PTE_SHIFT = 3;  // 8-byte entries
endpackage

// File: rtl/xlate_tlb.sv
module xlate_tlb #(
  parameter int DEPTH   = 8,
  parameter int VPN_W   = 20,
  parameter int FRAME_W = 20
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               flush_i,
  input  logic [VPN_W-1:0]   lk_vpn_i,
  output logic               lk_hit_o,
  output logic [FRAME_W-1:0] lk_frame_o,
  input  logic               wr_en_i,
  input  logic [VPN_W-1:0]   wr_vpn_i,
  input  logic [FRAME_W-1:0] wr_frame_i
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0]   vld_q;
  logic [DEPTH-1:0]   match;
  logic [VPN_W-1:0]   vpn_q [DEPTH];
  logic [FRAME_W-1:0] frm_q [DEPTH];
  logic [IDX_W-1:0]   rr_q;
  logic [IDX_W-1:0]   victim;
  logic               free_found;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign match[g] = vld_q[g] && (vpn_q[g] == lk_vpn_i);
  end

  assign lk_hit_o = |match;

  always_comb begin
    lk_frame_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (match[i]) lk_frame_o = lk_frame_o | frm_q[i];
    end
  end

  // descending scan so the lowest empty slot wins
  always_comb begin
    victim     = rr_q;
    free_found = 1'b0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!vld_q[i]) begin
        victim     = IDX_W'(i);
        free_found = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      rr_q  <= '0;
    end else if (flush_i) begin
      vld_q <= '0;
    end else if (wr_en_i) begin
      vld_q[victim] <= 1'b1;
      if (!free_found) begin
        rr_q <= (rr_q == IDX_W'(DEPTH - 1)) ? '0 : rr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i && !flush_i) begin
      vpn_q[victim] <= wr_vpn_i;
      frm_q[victim] <= wr_frame_i;
    end
  end
endmodule

// File: rtl/xlate_ctrl.sv
module xlate_ctrl
  import page_xlate_pkg::*;
#(
  parameter int VPN_W     = 20,
  parameter int FRAME_W   = 20,
  parameter int PAGE_BITS = 12,
  parameter int MEM_DW    = 64
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         req_valid_i,
  output logic                         req_ready_o,
  input  logic [VPN_W-1:0]             vpn_i,
  input  logic [PAGE_BITS-1:0]         off_i,
  input  logic [VPN_W:0]               ptlr_i,
  input  logic                         flush_i,
  input  logic                         tlb_hit_i,
  input  logic [FRAME_W-1:0]           tlb_frame_i,
  output logic                         mem_issue_o,
  output logic                         mem_cancel_o,
  input  logic                         mem_dvalid_i,
  input  logic [MEM_DW-1:0]            mem_data_i,
  output logic                         fill_en_o,
  output logic [VPN_W-1:0]             fill_vpn_o,
  output logic [FRAME_W-1:0]           fill_frame_o,
  output logic                         rsp_valid_o,
  output logic [FRAME_W+PAGE_BITS-1:0] rsp_paddr_o,
  output logic [1:0]                   rsp_fault_o
);
  xlate_state_e                  state_q;
  logic [VPN_W-1:0]              vpn_q;
  logic [PAGE_BITS-1:0]          off_q;
  logic                          cancel_q;
  logic                          drop_q;
  logic [FRAME_W+PAGE_BITS-1:0]  paddr_q;
  fault_e                        fault_q;

  logic                          accept;
  logic                          in_bounds;
  logic                          pte_valid;
  logic [FRAME_W-1:0]            pte_frame;
  logic                          unused_pte;

  assign req_ready_o = (state_q == S_IDLE) && !flush_i;
  assign accept      = req_valid_i && req_ready_o;
  assign in_bounds   = {1'b0, vpn_i} < ptlr_i;
  assign pte_valid   = mem_data_i[MEM_DW-1];
  assign pte_frame   = mem_data_i[FRAME_W-1:0];
  assign unused_pte  = ^mem_data_i[MEM_DW-2:FRAME_W];

  assign mem_issue_o  = accept;
  assign mem_cancel_o = cancel_q;
  assign fill_en_o    = (state_q == S_WAIT) && mem_dvalid_i && pte_valid && !drop_q && !flush_i;
  assign fill_vpn_o   = vpn_q;
  assign fill_frame_o = pte_frame;
  assign rsp_valid_o  = (state_q == S_DONE);
  assign rsp_paddr_o  = paddr_q;
  assign rsp_fault_o  = fault_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      vpn_q    <= '0;
      off_q    <= '0;
      cancel_q <= 1'b0;
      drop_q   <= 1'b0;
      paddr_q  <= '0;
      fault_q  <= FLT_NONE;
    end else begin
      unique case (state_q)
        S_IDLE: begin
          if (accept) begin
            vpn_q  <= vpn_i;
            off_q  <= off_i;
            drop_q <= 1'b0;
            if (!in_bounds) begin
              paddr_q  <= '0;
              fault_q  <= FLT_BOUNDS;
              cancel_q <= 1'b1;
              state_q  <= S_DONE;
            end else if (tlb_hit_i) begin
              paddr_q  <= {tlb_frame_i, off_i};
              fault_q  <= FLT_NONE;
              cancel_q <= 1'b1;
              state_q  <= S_DONE;
            end else begin
              state_q <= S_WAIT;
            end
          end
        end
        S_WAIT: begin
          if (flush_i) drop_q <= 1'b1;
          if (mem_dvalid_i) begin
            state_q <= S_DONE;
            if (pte_valid) begin
              paddr_q <= {pte_frame, off_q};
              fault_q <= FLT_NONE;
            end else begin
              paddr_q <= '0;
              fault_q <= FLT_INVALID;
            end
          end
        end
        S_DONE: begin
          cancel_q <= 1'b0;
          state_q  <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/page_xlate.sv
module page_xlate
  import page_xlate_pkg::*;
#(
  parameter int LA_W      = 32,
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int DEPTH     = 8,
  parameter int MEM_AW    = 32,
  parameter int MEM_DW    = 64
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      req_valid_i,
  output logic                      req_ready_o,
  input  logic [LA_W-1:0]           req_laddr_i,
  output logic                      rsp_valid_o,
  output logic [PA_W-1:0]           rsp_paddr_o,
  output logic [1:0]                rsp_fault_o,
  output logic                      mem_rd_valid_o,
  output logic [MEM_AW-1:0]         mem_rd_addr_o,
  output logic                      mem_rd_cancel_o,
  input  logic                      mem_rd_data_valid_i,
  input  logic [MEM_DW-1:0]         mem_rd_data_i,
  input  logic [MEM_AW-1:0]         ptbr_i,
  input  logic [LA_W-PAGE_BITS:0]   ptlr_i,
  input  logic                      flush_i
);
  localparam int VPN_W   = LA_W - PAGE_BITS;
  localparam int FRAME_W = PA_W - PAGE_BITS;

  logic [VPN_W-1:0]     vpn;
  logic [PAGE_BITS-1:0] off;
  logic                 tlb_hit;
  logic [FRAME_W-1:0]   tlb_frame;
  logic                 fill_en;
  logic [VPN_W-1:0]     fill_vpn;
  logic [FRAME_W-1:0]   fill_frame;

  assign vpn = req_laddr_i[LA_W-1:PAGE_BITS];
  assign off = req_laddr_i[PAGE_BITS-1:0];

  assign mem_rd_addr_o = ptbr_i + (MEM_AW'(vpn) << PTE_SHIFT);

  xlate_tlb #(
    .DEPTH  (DEPTH),
    .VPN_W  (VPN_W),
    .FRAME_W(FRAME_W)
  ) u_tlb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flush_i   (flush_i),
    .lk_vpn_i  (vpn),
    .lk_hit_o  (tlb_hit),
    .lk_frame_o(tlb_frame),
    .wr_en_i   (fill_en),
    .wr_vpn_i  (fill_vpn),
    .wr_frame_i(fill_frame)
  );

  xlate_ctrl #(
    .VPN_W    (VPN_W),
    .FRAME_W  (FRAME_W),
    .PAGE_BITS(PAGE_BITS),
    .MEM_DW   (MEM_DW)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_ready_o (req_ready_o),
    .vpn_i       (vpn),
    .off_i       (off),
    .ptlr_i      (ptlr_i),
    .flush_i     (flush_i),
    .tlb_hit_i   (tlb_hit),
    .tlb_frame_i (tlb_frame),
    .mem_issue_o (mem_rd_valid_o),
    .mem_cancel_o(mem_rd_cancel_o),
    .mem_dvalid_i(mem_rd_data_valid_i),
    .mem_data_i  (mem_rd_data_i),
    .fill_en_o   (fill_en),
    .fill_vpn_o  (fill_vpn),
    .fill_frame_o(fill_frame),
    .rsp_valid_o (rsp_valid_o),
    .rsp_paddr_o (rsp_paddr_o),
    .rsp_fault_o (rsp_fault_o)
  );
endmodule

// File: rtl/page_xlate_chk.sv
module page_xlate_chk #(
  parameter int LA_W      = 32,
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 12
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    req_valid_i,
  input logic                    req_ready_o,
  input logic [LA_W-1:0]         req_laddr_i,
  input logic                    rsp_valid_o,
  input logic [PA_W-1:0]         rsp_paddr_o,
  input logic [1:0]              rsp_fault_o,
  input logic                    mem_rd_valid_o,
  input logic                    mem_rd_cancel_o,
  input logic [LA_W-PAGE_BITS:0] ptlr_i,
  input logic                    flush_i
);
  localparam int VPN_W = LA_W - PAGE_BITS;

  logic [VPN_W-1:0]     last_vpn;
  logic [PAGE_BITS-1:0] last_off;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_vpn <= '0;
      last_off <= '0;
    end else if (req_valid_i && req_ready_o) begin
      last_vpn <= req_laddr_i[LA_W-1:PAGE_BITS];
      last_off <= req_laddr_i[PAGE_BITS-1:0];
    end
  end

  p_offset_kept_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o == 2'd0) |-> rsp_paddr_o[PAGE_BITS-1:0] == last_off);

  p_read_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_valid_o |=> !mem_rd_valid_o);

  p_cancel_follows_read_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_cancel_o |-> $past(mem_rd_valid_o));

  p_bounds_fault_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o == 2'd1) |-> ({1'b0, last_vpn} >= ptlr_i));

  p_flush_stalls_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |-> !req_ready_o);

  p_busy_after_accept_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

  p_rsp_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  p_fault_code_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> rsp_fault_o != 2'd3);

  p_fault_zero_addr_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o != 2'd0) |-> rsp_paddr_o == '0);
endmodule

bind page_xlate page_xlate_chk #(
  .LA_W     (LA_W),
  .PA_W     (PA_W),
  .PAGE_BITS(PAGE_BITS)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .req_valid_i    (req_valid_i),
  .req_ready_o    (req_ready_o),
  .req_laddr_i    (req_laddr_i),
  .rsp_valid_o    (rsp_valid_o),
  .rsp_paddr_o    (rsp_paddr_o),
  .rsp_fault_o    (rsp_fault_o),
  .mem_rd_valid_o (mem_rd_valid_o),
  .mem_rd_cancel_o(mem_rd_cancel_o),
  .ptlr_i         (ptlr_i),
  .flush_i        (flush_i)
);

// File: tb/page_xlate_bench.sv
module page_xlate_bench;
  localparam int LAT   = 3;
  localparam int DEPTH = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        req_valid_i;
  logic        req_ready_o;
  logic [31:0] req_laddr_i;
  logic        rsp_valid_o;
  logic [31:0] rsp_paddr_o;
  logic [1:0]  rsp_fault_o;
  logic        mem_rd_valid_o;
  logic [31:0] mem_rd_addr_o;
  logic        mem_rd_cancel_o;
  logic        mem_rd_data_valid_i;
  logic [63:0] mem_rd_data_i;
  logic [31:0] ptbr_i;
  logic [20:0] ptlr_i;
  logic        flush_i;

  always #5 clk_i = ~clk_i;

  page_xlate u_page_xlate (.*);

  typedef struct {
    logic [31:0] paddr;
    logic [1:0]  fault;
    bit          quick;
    int          acc;
    string       req;
  } exp_t;

  exp_t sb[$];
  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  logic [19:0] m_vpn [DEPTH];
  logic [19:0] m_frm [DEPTH];
  bit          m_vld [DEPTH];
  int          m_rr = 0;

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] pte_of(input logic [19:0] vpn);
    logic [19:0] f;
    f = 20'(vpn * 7 + 20'h31000);
    return {((vpn % 5) != 3), 43'h0, f};
  endfunction

  task automatic flush_model();
    for (int i = 0; i < DEPTH; i++) m_vld[i] = 1'b0;
  endtask

  task automatic xlate(input logic [31:0] la, input bit drop, input string tag);
    exp_t        e;
    logic [19:0] vpn;
    logic [63:0] pte;
    int          hit_idx;
    int          slot;
    bit          acc;
    int          a_cyc;
    vpn     = la[31:12];
    hit_idx = -1;
    for (int i = 0; i < DEPTH; i++) if (m_vld[i] && m_vpn[i] == vpn) hit_idx = i;
    e.req = tag;
    if ({1'b0, vpn} >= ptlr_i) begin
      e.paddr = '0; e.fault = 2'd1; e.quick = 1'b1;
    end else if (hit_idx >= 0) begin
      e.paddr = {m_frm[hit_idx], la[11:0]}; e.fault = 2'd0; e.quick = 1'b1;
    end else begin
      pte     = pte_of(vpn);
      e.quick = 1'b0;
      if (pte[63]) begin
        e.paddr = {pte[19:0], la[11:0]}; e.fault = 2'd0;
        if (!drop) begin
          slot = -1;
          for (int i = DEPTH - 1; i >= 0; i--) if (!m_vld[i]) slot = i;
          if (slot < 0) begin
            slot = m_rr;
            m_rr = (m_rr + 1) % DEPTH;
          end
          m_vld[slot] = 1'b1; m_vpn[slot] = vpn; m_frm[slot] = pte[19:0];
        end
      end else begin
        e.paddr = '0; e.fault = 2'd2;
      end
    end
    @(negedge clk_i);
    req_valid_i = 1'b1;
    req_laddr_i = la;
    do begin
      #1;
      acc   = req_ready_o;
      a_cyc = cyc;
      @(posedge clk_i);
    end while (!acc);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    e.acc = a_cyc;
    sb.push_back(e);
    #1;
    chk(req_ready_o == 1'b0, "R10", "ready while busy", 64'(req_ready_o), 64'd0);
  endtask

  task automatic wait_idle();
    while (sb.size() != 0) @(negedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic flush_pulse();
    @(negedge clk_i);
    flush_i = 1'b1;
    #1;
    chk(req_ready_o == 1'b0, "R9", "ready during flush", 64'(req_ready_o), 64'd0);
    @(negedge clk_i);
    flush_i = 1'b0;
    flush_model();
  endtask

  // memory model: one pending read, fixed latency, dropped on cancel
  initial begin
    logic [19:0] pvpn;
    bit          pend;
    int          cnt;
    mem_rd_data_valid_i = 1'b0;
    mem_rd_data_i       = '0;
    pend = 1'b0;
    cnt  = 0;
    pvpn = '0;
    forever begin
      @(negedge clk_i);
      #2;
      mem_rd_data_valid_i = 1'b0;
      if (pend) begin
        if (mem_rd_cancel_o) pend = 1'b0;
        else begin
          cnt--;
          if (cnt == 0) begin
            mem_rd_data_i       = pte_of(pvpn);
            mem_rd_data_valid_i = 1'b1;
            pend                = 1'b0;
          end
        end
      end
      if (mem_rd_valid_o) begin
        pvpn = req_laddr_i[31:12];
        chk(req_valid_i && req_ready_o, "R2", "read outside accept", 64'(req_valid_i), 64'd1);
        chk(mem_rd_addr_o == ptbr_i + {9'd0, pvpn, 3'd0}, "R2", "pte address",
            64'(mem_rd_addr_o), 64'(ptbr_i + {9'd0, pvpn, 3'd0}));
        pend = 1'b1;
        cnt  = LAT;
      end
    end
  end

  // monitor / scoreboard
  initial begin
    exp_t e;
    forever begin
      @(negedge clk_i);
      #1;
      if (rsp_valid_o) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R10", "unexpected response", 64'(rsp_paddr_o), 64'd0);
        end else begin
          e = sb.pop_front();
          chk(rsp_paddr_o == e.paddr, e.req, "paddr", 64'(rsp_paddr_o), 64'(e.paddr));
          chk(rsp_fault_o == e.fault, e.req, "fault", 64'(rsp_fault_o), 64'(e.fault));
          chk((cyc - e.acc) == (e.quick ? 1 : LAT + 1), e.req, "latency",
              64'(cyc - e.acc), 64'(e.quick ? 1 : LAT + 1));
          chk(mem_rd_cancel_o == e.quick, e.req, "cancel", 64'(mem_rd_cancel_o), 64'(e.quick));
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog R10 act=hung exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_ni      = 1'b0;
    req_valid_i = 1'b0;
    req_laddr_i = '0;
    ptbr_i      = 32'h0010_0000;
    ptlr_i      = 21'd64;
    flush_i     = 1'b0;
    flush_model();
    repeat (3) @(negedge clk_i);
    #1;
    chk(req_ready_o == 1'b1, "R10", "reset ready", 64'(req_ready_o), 64'd1);
    chk(rsp_valid_o == 1'b0, "R10", "reset rsp", 64'(rsp_valid_o), 64'd0);
    chk(mem_rd_valid_o == 1'b0, "R2", "reset read", 64'(mem_rd_valid_o), 64'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R4 miss then R7 / R3 hit, R1 offset extremes
    xlate(32'h0000_1234, 1'b0, "R4");
    xlate(32'h0000_1000, 1'b0, "R7");
    xlate(32'h0000_1FFF, 1'b0, "R1");
    // R6 invalid entry, twice
    xlate(32'h0000_3010, 1'b0, "R6");
    xlate(32'h0000_3020, 1'b0, "R6");
    // R5 bounds fault, then in range after raising the length
    xlate(32'h0004_6ABC, 1'b0, "R5");
    xlate(32'h0003_F001, 1'b0, "R3");
    wait_idle();
    ptlr_i = 21'd128;
    xlate(32'h0004_6ABC, 1'b0, "R5");
    // R8 fill and round-robin eviction
    for (int p = 30; p < 42; p++) xlate({12'd0, 8'(p), 12'h0A5}, 1'b0, "R8");
    xlate(32'h0000_1777, 1'b0, "R8");
    xlate({12'd0, 8'd41, 12'h000}, 1'b0, "R8");
    xlate({12'd0, 8'd30, 12'h123}, 1'b0, "R8");
    xlate(32'h0004_6ABC, 1'b0, "R7");
    // R9 flush empties the buffer
    wait_idle();
    flush_pulse();
    xlate({12'd0, 8'd41, 12'hFFF}, 1'b0, "R9");
    xlate({12'd0, 8'd41, 12'h001}, 1'b0, "R7");
    // R12 flush while a miss waits
    wait_idle();
    xlate(32'h0001_4400, 1'b1, "R12");
    flush_pulse();
    wait_idle();
    xlate(32'h0001_4404, 1'b0, "R12");
    xlate(32'h0001_4408, 1'b0, "R3");
    wait_idle();
    repeat (4) @(negedge clk_i);
    chk(sb.size() == 0, "R10", "pending responses", 64'(sb.size()), 64'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule